// File: doc/BRIEF.md
# Prescaled Match Timer with PWM Outputs

This block is a free-running up-counter with a programmable clock divider in front of it and a set of compare channels behind it. Each channel holds a compare value. When the running count equals that value on a counting step, the channel can return the count to zero, halt the counter, latch a pending-event flag, and change the level of its own output pin. The pin can be left alone, forced low, forced high or inverted.

A channel can be switched to waveform mode. Its pin then shows whether the count has reached the channel's compare value. Paired with a second channel that returns the count to zero, this gives a pulse-width-modulated signal. The second channel sets the period and the first sets where the edge falls inside it. All configuration and status lives in a small word-addressed register file that is written in single cycles and read back combinationally. The `irq` output is raised while any pending-event flag is set.

Top module: `pwm_match_timer`

## Requirements
- R1: After reset the counter, divider setting, run bit, event flags, compare values, pin levels and waveform enables all read as zero, and `irq` and `match_out` are low.
- R2: While running with divider value P (register 1), the count advances by one once every P+1 clock cycles. With P=0 it advances on every cycle.
- R3: The counter advances only while the run bit (register 0, bit 0) is 1. Writing 0 there freezes the count at its current value.
- R4: A channel whose compare-action bit 3·ch (register 3) is set returns the count to zero on the step where the count equals its compare value. The count therefore cycles through 0 to M.
- R5: A channel whose compare-action bit 3·ch+1 is set clears the run bit on a compare hit, and the count stays at the compare value.
- R6: When both bit 3·ch and bit 3·ch+1 are set, a hit leaves the count at zero and the run bit cleared.
- R7: A channel whose compare-action bit 3·ch+2 is set raises flag bit ch (register 6) on a hit. Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. `irq` is high exactly while at least one flag is set.
- R8: Register 4 holds the pin level of each channel in bits [N-1:0] and a 2-bit hit action per channel at bits N+2·ch. The codes are 00 keep, 01 drive low, 10 drive high, 11 invert. A channel outside waveform mode drives this level on `match_out[ch]`.
- R9: A channel whose bit is set in register 5 drives `match_out[ch]` low while the count is below its compare value and high once the count has reached it. A compare value of 0 gives a constant high level.
- R10: In waveform mode, a compare value larger than the largest count that the period channel allows keeps `match_out[ch]` low for the whole period.
- R11: Register addresses are 0 run control, 1 divider, 2 count (a write loads the count and restarts the divider), 3 compare actions, 4 pin levels and actions, 5 waveform enables, 6 event flags, and 8+ch the compare value of channel ch. Every register reads back what was last written or updated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_we | input | 1 | Single-cycle register write strobe |
| bus_addr | input | 4 | Word address for reads and writes |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Combinational read data for `bus_addr` |
| match_out | output | NUM_CH | Per-channel output pin level |
| irq | output | 1 | High while any event flag is pending |

## Verification
The properties assume that `bus_we` and `bus_addr` are never unknown after reset, and that a write lasts exactly one cycle. They also assume that only a write to the count register changes the count outside the counting logic, so every counter property excludes that cycle. The stimulus drives each write for a single clock and changes inputs only in the low phase of the clock. It rewrites the count to zero before every scenario, so compare hits land on cycles that can be computed in advance.

// File: rtl/pmt_pkg.sv
`timescale 1ns/1ps
package pmt_pkg;
  localparam int unsigned ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_RUN    = 4'd0;
  localparam logic [ADDR_W-1:0] A_DIV    = 4'd1;
  localparam logic [ADDR_W-1:0] A_COUNT  = 4'd2;
  localparam logic [ADDR_W-1:0] A_ACT    = 4'd3;
  localparam logic [ADDR_W-1:0] A_PIN    = 4'd4;
  localparam logic [ADDR_W-1:0] A_WAVE   = 4'd5;
  localparam logic [ADDR_W-1:0] A_FLAG   = 4'd6;
  localparam int unsigned       A_CMP0   = 8;

  typedef enum logic [1:0] {
    PIN_KEEP = 2'b00,
    PIN_LOW  = 2'b01,
    PIN_HIGH = 2'b10,
    PIN_FLIP = 2'b11
  } pin_act_e;
endpackage

// File: rtl/pmt_prescaler.sv
`timescale 1ns/1ps
module pmt_prescaler #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [CNT_W-1:0] limit,
  output logic             tick,
  output logic [CNT_W-1:0] phase
);
  logic [CNT_W-1:0] phase_d;

  assign tick = run && (phase == limit);

  always_comb begin
    if (!run || restart || tick) phase_d = '0;
    else                          phase_d = phase + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= '0;
    else        phase <= phase_d;
  end
endmodule

// File: rtl/pmt_channel.sv
`timescale 1ns/1ps
module pmt_channel import pmt_pkg::*; #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             step,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] cmp_val,
  input  pin_act_e         pin_act,
  input  logic             pin_cur,
  input  logic             wave_en,
  output logic             hit,
  output logic             pin_nxt,
  output logic             pin_lvl
);
  assign hit = step && (count == cmp_val);

  always_comb begin
    pin_nxt = pin_cur;
    if (hit) begin
      unique case (pin_act)
        PIN_KEEP: pin_nxt = pin_cur;
        PIN_LOW:  pin_nxt = 1'b0;
        PIN_HIGH: pin_nxt = 1'b1;
        PIN_FLIP: pin_nxt = ~pin_cur;
      endcase
    end
  end

  assign pin_lvl = wave_en ? (count >= cmp_val) : pin_cur;
endmodule

// File: rtl/pwm_match_timer.sv
`timescale 1ns/1ps
module pwm_match_timer import pmt_pkg::*; #(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic [NUM_CH-1:0] match_out,
  output logic              irq
);
  localparam int unsigned ACT_W = 3 * NUM_CH;
  localparam int unsigned SEL_W = 2 * NUM_CH;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ni = rst_pipe[1];

  // state
  logic              run_q,   run_d;
  logic [CNT_W-1:0]  div_q,   div_d;
  logic [CNT_W-1:0]  cnt_q,   cnt_d;
  logic [ACT_W-1:0]  act_q,   act_d;
  logic [NUM_CH-1:0] pin_q,   pin_d;
  logic [SEL_W-1:0]  sel_q,   sel_d;
  logic [NUM_CH-1:0] wave_q,  wave_d;
  logic [NUM_CH-1:0] flag_q,  flag_d;
  logic [CNT_W-1:0]  cmp_q [NUM_CH];
  logic [CNT_W-1:0]  cmp_d [NUM_CH];

  // write decode
  logic wr_run, wr_div, wr_cnt, wr_act, wr_pin, wr_wave, wr_flag;
  assign wr_run  = bus_we && (bus_addr == A_RUN);
  assign wr_div  = bus_we && (bus_addr == A_DIV);
  assign wr_cnt  = bus_we && (bus_addr == A_COUNT);
  assign wr_act  = bus_we && (bus_addr == A_ACT);
  assign wr_pin  = bus_we && (bus_addr == A_PIN);
  assign wr_wave = bus_we && (bus_addr == A_WAVE);
  assign wr_flag = bus_we && (bus_addr == A_FLAG);

  // divider
  logic             tick, step;
  logic [CNT_W-1:0] pre_phase;
  pmt_prescaler #(.CNT_W(CNT_W)) u_prescaler (
    .clk    (clk),
    .rst_n  (rst_ni),
    .run    (run_q),
    .restart(wr_cnt),
    .limit  (div_q),
    .tick   (tick),
    .phase  (pre_phase)
  );
  assign step = tick;

  // channels
  logic [NUM_CH-1:0] hit, pin_nxt, zero_en, halt_en, evt_en;
  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    pmt_channel #(.CNT_W(CNT_W)) u_channel (
      .step   (step),
      .count  (cnt_q),
      .cmp_val(cmp_q[i]),
      .pin_act(pin_act_e'(sel_q[2*i +: 2])),
      .pin_cur(pin_q[i]),
      .wave_en(wave_q[i]),
      .hit    (hit[i]),
      .pin_nxt(pin_nxt[i]),
      .pin_lvl(match_out[i])
    );
    assign zero_en[i] = act_q[3*i];
    assign halt_en[i] = act_q[3*i + 1];
    assign evt_en[i]  = act_q[3*i + 2];
  end

  logic any_zero, any_halt;
  assign any_zero = |(hit & zero_en);
  assign any_halt = |(hit & halt_en);

  // next state
  always_comb begin
    div_d  = wr_div  ? bus_wdata              : div_q;
    act_d  = wr_act  ? bus_wdata[ACT_W-1:0]   : act_q;
    wave_d = wr_wave ? bus_wdata[NUM_CH-1:0]  : wave_q;
    sel_d  = wr_pin  ? bus_wdata[NUM_CH +: SEL_W] : sel_q;
    pin_d  = wr_pin  ? bus_wdata[NUM_CH-1:0]  : pin_nxt;

    if (any_halt)    run_d = 1'b0;
    else if (wr_run) run_d = bus_wdata[0];
    else             run_d = run_q;

    if (wr_cnt)        cnt_d = bus_wdata;
    else if (step) begin
      if (any_zero)      cnt_d = '0;
      else if (any_halt) cnt_d = cnt_q;
      else               cnt_d = cnt_q + 1'b1;
    end
    else               cnt_d = cnt_q;

    flag_d = (flag_q & ~(wr_flag ? bus_wdata[NUM_CH-1:0] : '0)) | (hit & evt_en);

    for (int i = 0; i < NUM_CH; i++) begin
      cmp_d[i] = (bus_we && (bus_addr == ADDR_W'(A_CMP0 + i))) ? bus_wdata : cmp_q[i];
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      div_q  <= '0;
      cnt_q  <= '0;
      act_q  <= '0;
      pin_q  <= '0;
      sel_q  <= '0;
      wave_q <= '0;
      flag_q <= '0;
      for (int i = 0; i < NUM_CH; i++) cmp_q[i] <= '0;
    end else begin
      run_q  <= run_d;
      div_q  <= div_d;
      cnt_q  <= cnt_d;
      act_q  <= act_d;
      pin_q  <= pin_d;
      sel_q  <= sel_d;
      wave_q <= wave_d;
      flag_q <= flag_d;
      for (int i = 0; i < NUM_CH; i++) cmp_q[i] <= cmp_d[i];
    end
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      A_RUN:   bus_rdata = CNT_W'(run_q);
      A_DIV:   bus_rdata = div_q;
      A_COUNT: bus_rdata = cnt_q;
      A_ACT:   bus_rdata = CNT_W'(act_q);
      A_PIN:   bus_rdata = CNT_W'({sel_q, pin_q});
      A_WAVE:  bus_rdata = CNT_W'(wave_q);
      A_FLAG:  bus_rdata = CNT_W'(flag_q);
      default: begin
        for (int i = 0; i < NUM_CH; i++) begin
          if (bus_addr == ADDR_W'(A_CMP0 + i)) bus_rdata = cmp_q[i];
        end
      end
    endcase
  end

  assign irq = |flag_q;
endmodule

// File: rtl/pmt_checker.sv
`timescale 1ns/1ps
module pmt_checker #(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned NUM_CH = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  run,
  input logic [CNT_W-1:0]      cnt,
  input logic [CNT_W-1:0]      phase,
  input logic [CNT_W-1:0]      presc,
  input logic                  wr_cnt,
  input logic [NUM_CH-1:0]     hit,
  input logic [3*NUM_CH-1:0]   mact,
  input logic [NUM_CH-1:0]     flags
);
  logic [NUM_CH-1:0] c_zero, c_halt, c_evt;
  always_comb begin
    for (int i = 0; i < NUM_CH; i++) begin
      c_zero[i] = mact[3*i];
      c_halt[i] = mact[3*i + 1];
      c_evt[i]  = mact[3*i + 2];
    end
  end

  AST_DIVIDER_GATES_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != presc && !wr_cnt) |=> $stable(cnt)); // R2

  AST_IDLE_HOLDS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_cnt) |=> $stable(cnt)); // R3

  AST_ZERO_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(hit & c_zero)) && !wr_cnt) |=> (cnt == '0)); // R4

  AST_HALT_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (|(hit & c_halt)) |=> !run); // R5

  AST_FLAG_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(hit & c_evt)) |=> ((flags & ~$past(flags)) == '0)); // R7
endmodule

bind pwm_match_timer pmt_checker #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) u_pmt_checker (
  .clk   (clk),
  .rst_n (rst_n),
  .run   (run_q),
  .cnt   (cnt_q),
  .phase (pre_phase),
  .presc (div_q),
  .wr_cnt(wr_cnt),
  .hit   (hit),
  .mact  (act_q),
  .flags (flag_q)
);

// File: tb/pwm_match_timer_bench.sv
`timescale 1ns/1ps
module pwm_match_timer_bench;
  localparam int CNT_W = 32;
  localparam int NCH   = 4;
  localparam int K_RD  = 0;
  localparam int K_OUT = 1;
  localparam int K_IRQ = 2;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             bus_we;
  logic [3:0]       bus_addr;
  logic [CNT_W-1:0] bus_wdata;
  logic [CNT_W-1:0] bus_rdata;
  logic [NCH-1:0]   match_out;
  logic             irq;

  always #2.5 clk = ~clk;

  pwm_match_timer #(.CNT_W(CNT_W), .NUM_CH(NCH)) u_pwm_match_timer (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .match_out(match_out), .irq(irq)
  );

  typedef struct {
    string       tag;
    int          kind;
    logic [31:0] exp;
  } item_t;

  item_t sb_q[$];
  event  sb_ev;
  int    n_chk = 0;
  int    n_err = 0;
  bit    done  = 0;

  // monitor: pops expected items and compares with the live outputs
  always @(sb_ev) begin : monitor
    item_t       it;
    logic [31:0] got;
    while (sb_q.size() > 0) begin
      it = sb_q.pop_front();
      case (it.kind)
        K_RD:    got = bus_rdata;
        K_OUT:   got = 32'(match_out);
        default: got = 32'(irq);
      endcase
      n_chk++;
      if (got !== it.exp) begin
        n_err++;
        $display("FAIL %s: got %0h expected %0h", it.tag, got, it.exp);
      end
    end
  end

  // driver tasks
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_item(input string tag, input int kind, input logic [3:0] a,
                             input logic [31:0] e);
    bus_addr = a;
    #0.1;
    sb_q.push_back('{tag, kind, e});
    -> sb_ev;
    #0.1;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin : stim
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    idle(3);
    rst_n = 1'b1;
    idle(3);

    // R1 reset state
    expect_item("R1 run",   K_RD,  4'd0, 0);
    expect_item("R1 count", K_RD,  4'd2, 0);
    expect_item("R1 flags", K_RD,  4'd6, 0);
    expect_item("R1 cmp0",  K_RD,  4'd8, 0);
    expect_item("R1 pins",  K_OUT, 4'd0, 0);
    expect_item("R1 irq",   K_IRQ, 4'd0, 0);

    // R2 divider of 3
    wr(4'd1, 2);
    expect_item("R11 divider readback", K_RD, 4'd1, 2);
    wr(4'd0, 1);
    idle(9);  expect_item("R2 count after 9", K_RD, 4'd2, 3);
    idle(2);  expect_item("R2 count after 11", K_RD, 4'd2, 3);
    idle(1);  expect_item("R2 count after 12", K_RD, 4'd2, 4);

    // R3 halt
    wr(4'd0, 0);
    expect_item("R3 count at stop", K_RD, 4'd2, 4);
    idle(5);
    expect_item("R3 count frozen", K_RD, 4'd2, 4);
    expect_item("R3 run bit", K_RD, 4'd0, 0);

    // R4 zero on hit, period 5
    wr(4'd2, 0); wr(4'd1, 0); wr(4'd8, 4); wr(4'd3, 32'h1);
    wr(4'd0, 1);
    idle(4); expect_item("R4 count 4", K_RD, 4'd2, 4);
    idle(1); expect_item("R4 wrap to 0", K_RD, 4'd2, 0);
    idle(3); expect_item("R4 count 3", K_RD, 4'd2, 3);
    expect_item("R4 no flag without enable", K_RD, 4'd6, 0);

    // R7 event flag
    wr(4'd0, 0); wr(4'd2, 0); wr(4'd3, 32'h5);
    wr(4'd0, 1);
    idle(4);
    expect_item("R7 flag before hit", K_RD, 4'd6, 0);
    expect_item("R7 irq before hit", K_IRQ, 4'd0, 0);
    idle(1);
    expect_item("R7 flag on hit", K_RD, 4'd6, 1);
    expect_item("R7 irq on hit", K_IRQ, 4'd0, 1);
    wr(4'd0, 0);
    expect_item("R7 flag held", K_RD, 4'd6, 1);
    wr(4'd6, 32'h2);
    expect_item("R7 other bit no clear", K_RD, 4'd6, 1);
    wr(4'd6, 32'h1);
    expect_item("R7 cleared by 1", K_RD, 4'd6, 0);
    expect_item("R7 irq drops", K_IRQ, 4'd0, 0);

    // R5 halt on hit
    wr(4'd2, 0); wr(4'd9, 3); wr(4'd3, 32'h10);
    wr(4'd0, 1);
    idle(10);
    expect_item("R5 count held at cmp", K_RD, 4'd2, 3);
    expect_item("R5 run cleared", K_RD, 4'd0, 0);

    // R6 halt plus zero
    wr(4'd2, 0); wr(4'd3, 32'h18);
    wr(4'd0, 1);
    idle(10);
    expect_item("R6 count zero", K_RD, 4'd2, 0);
    expect_item("R6 run cleared", K_RD, 4'd0, 0);

    // R8 pin actions: ch0 low, ch1 high, ch2 invert, ch3 keep (ch3 halts)
    wr(4'd3, 32'h400);
    wr(4'd8, 2); wr(4'd9, 2); wr(4'd10, 2); wr(4'd11, 2);
    wr(4'd4, 32'h395);
    wr(4'd2, 0);
    expect_item("R8 initial levels", K_OUT, 4'd0, 32'h5);
    expect_item("R11 pin reg readback", K_RD, 4'd4, 32'h395);
    wr(4'd0, 1);
    idle(5);
    expect_item("R8 levels after hit", K_OUT, 4'd0, 32'h2);
    expect_item("R8 pin reg after hit", K_RD, 4'd4, 32'h392);
    expect_item("R5 stop only keeps count", K_RD, 4'd2, 2);
    expect_item("R8 no flags", K_RD, 4'd6, 0);

    // R9 waveform: period ch0=9, edge ch1=6
    wr(4'd3, 32'h1); wr(4'd4, 0);
    wr(4'd8, 9); wr(4'd9, 6); wr(4'd10, 20); wr(4'd11, 20);
    wr(4'd5, 32'h2);
    wr(4'd2, 0);
    expect_item("R11 wave enable readback", K_RD, 4'd5, 2);
    expect_item("R9 low at count 0", K_OUT, 4'd0, 0);
    wr(4'd0, 1);
    idle(5);  expect_item("R9 low below edge", K_OUT, 4'd0, 0);
    idle(1);  expect_item("R9 high at edge", K_OUT, 4'd0, 2);
    idle(3);  expect_item("R9 high at period end", K_OUT, 4'd0, 2);
    idle(1);  expect_item("R9 low after wrap", K_OUT, 4'd0, 0);
    expect_item("R4 wrap in waveform", K_RD, 4'd2, 0);

    // R10 unreachable edge
    wr(4'd9, 12);
    for (int i = 0; i < 12; i++) begin
      idle(1);
      expect_item("R10 constant low", K_OUT, 4'd0, 0);
    end
    // R9 compare 0 gives constant high
    wr(4'd9, 0);
    expect_item("R11 cmp1 readback", K_RD, 4'd9, 0);
    for (int i = 0; i < 6; i++) begin
      idle(1);
      expect_item("R9 constant high", K_OUT, 4'd0, 2);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule